// File: doc/BRIEF.md
# Serial Management Master

The block runs serial management transactions on a two-wire management bus, on behalf of a CPU that sees it as a small set of 16-bit registers. It divides the system clock by ten to make a management clock that never stops. It sends a 32-bit frame on that clock: a start pattern, an opcode, a 5-bit device address, a 5-bit register address, a two-bit turnaround and 16 data bits. There is no preamble. The data line is split into an output, an input and a direction pin. The direction pin tells an external buffer which side drives the line. An active-low valid strobe frames each transaction by half a management clock on either side.

The CPU stores the fields in the command register and, for writes, a data word in the write-data register. It then writes 1 to the start bit. The start bit reads back as 1 until the transaction completes. On completion the block pulses `done_o`. If any read saw the slave fail to drive the second turnaround bit low, it also pulses `rd_err_o`. A block read fetches seven consecutive device registers in seven back-to-back frames and places the results in seven read-data registers.

Register map (word addresses on `reg_addr_i`): 0 control, with bit 0 as start/busy; 1 command; 2 write data; 3 to 9 read data 0 to 6.

Top module: `smi_master`

## Requirements
- R1: After reset, `mdv_no` = 1, `dir_o` = 0 and `mdio_o` = 1, and the control and read-data registers read 0.
- R2: `mdc_o` toggles continuously, staying 5 system clocks high and 5 system clocks low.
- R3: A frame is 32 bits, sent MSB first. Bits 0-1 are 01. Bits 2-3 are the opcode from command bits 11:10. Bits 4-8 are the device address from command bits 9:5. Bits 9-13 are the register address from command bits 4:0. Bits 14-15 are the turnaround. Bits 16-31 are data. On writes the turnaround is driven as 10 and the data comes from the write-data register.
- R4: `mdio_o` and `dir_o` change only on a falling edge of `mdc_o`. Incoming bits are sampled on the rising edge.
- R5: With opcode 10 (read), `dir_o` is 1 for frame bits 0-13 and 0 from bit 14 on. With any other opcode it is 1 for all 32 bits. Outside frames it is 0.
- R6: `mdv_no` falls on the `mdc_o` rising edge just before bit 0 is driven. It rises on the rising edge half a clock after bit 31 ends.
- R7: A single read places the 16 sampled data bits, MSB first, in read data 0 (address 3).
- R8: If the second turnaround bit of a read is sampled as 1, `rd_err_o` pulses together with `done_o`. Otherwise `rd_err_o` stays 0.
- R9: Writing 1 to bit 0 of address 0 starts a transaction. That bit reads 1 until completion and then 0. `done_o` pulses for one cycle at completion.
- R10: With command bit 12 = 1 and a read opcode, seven frames are run to register addresses incrementing modulo 32. Their results go to addresses 3 to 9 in order, and `done_o` pulses once, after the last frame.
- R11: Register writes made while a transaction is in progress are ignored, including a second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (25 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| done_o | output | 1 | One-cycle completion pulse |
| rd_err_o | output | 1 | One-cycle invalid-read pulse |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_i | input | 1 | Management data in |
| dir_o | output | 1 | 1 while the master drives the data line |
| mdv_no | output | 1 | Transaction valid strobe, active low |

## Verification
A frame's results appear only at specific rising edges of the management clock, each ten system clocks apart:
- Read data is captured on the 32nd rising edge after the strobe falls and reaches its register one system clock later.
- `done_o` and `rd_err_o` follow on the next rising edge, half a management clock after the frame ends.

The bench therefore waits for the `done_o` pulse and only then reads registers and compares the captured frame. It samples everything, including the register read mux, on the falling system-clock edge or 1 ns after it.

Its slave model counts rising `mdc_o` edges while the strobe is low. It captures bit n on rise n+1 and drives its reply on the falling edge that starts the bit, five clocks before the master samples it.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] TA_WR = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_SHIFT,
    ST_TAIL
  } smi_state_e;
endpackage

// File: rtl/smi_clkgen.sv
module smi_clkgen #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV / 2;
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] ph_q;

  assign rise_o = (ph_q == CW'(DIV - 1));
  assign fall_o = (ph_q == CW'(HALF - 1));

  // start mid-period so the first low phase is a full half period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= CW'(HALF);
      mdc_o <= 1'b0;
    end else begin
      ph_q <= rise_o ? '0 : ph_q + 1'b1;
      if (rise_o) mdc_o <= 1'b1;
      else if (fall_o) mdc_o <= 1'b0;
    end
  end
endmodule

// File: rtl/smi_regs.sv
module smi_regs #(
  parameter int DW   = 16,
  parameter int AW   = 5,
  parameter int NBLK = 7,
  parameter int RAW  = 4,
  localparam int CMD_W = 2 * AW + 3,
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RAW-1:0]   addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             busy_i,
  output logic             start_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [DW-1:0]    wr_o,
  input  logic             cap_we_i,
  input  logic [IW-1:0]    cap_idx_i,
  input  logic [DW-1:0]    cap_data_i
);
  localparam int A_CTRL  = 0;
  localparam int A_CMD   = 1;
  localparam int A_WDATA = 2;
  localparam int RD_BASE = 3;

  logic [CMD_W-1:0] cmd_q;
  logic [DW-1:0]    wr_q;
  logic [DW-1:0]    rd_q [NBLK];
  logic             wr_ok;

  assign wr_ok   = we_i && !busy_i;
  assign start_o = wr_ok && (addr_i == RAW'(A_CTRL)) && wdata_i[0];
  assign cmd_o   = cmd_q;
  assign wr_o    = wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      wr_q  <= '0;
    end else if (wr_ok) begin
      if (addr_i == RAW'(A_CMD))   cmd_q <= wdata_i[CMD_W-1:0];
      if (addr_i == RAW'(A_WDATA)) wr_q  <= wdata_i;
    end
  end

  for (genvar i = 0; i < NBLK; i++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q[i] <= '0;
      else if (cap_we_i && (cap_idx_i == IW'(i))) rd_q[i] <= cap_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == RAW'(A_CTRL)) rdata_o[0] = busy_i;
    if (addr_i == RAW'(A_CMD)) rdata_o[CMD_W-1:0] = cmd_q;
    if (addr_i == RAW'(A_WDATA)) rdata_o = wr_q;
    for (int i = 0; i < NBLK; i++) begin
      if (addr_i == RAW'(RD_BASE + i)) rdata_o = rd_q[i];
    end
  end
endmodule

// File: rtl/smi_engine.sv
module smi_engine
  import smi_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 5,
  parameter int NBLK = 7,
  localparam int CMD_W = 2 * AW + 3,
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             dir_o,
  output logic             mdv_no,
  output logic             busy_o,
  output logic             done_o,
  output logic             rd_err_o,
  output logic             cap_we_o,
  output logic [IW-1:0]    cap_idx_o,
  output logic [DW-1:0]    cap_data_o
);
  localparam int FW  = 6 + 2 * AW + DW;  // frame length
  localparam int REL = 4 + 2 * AW;       // first bit released on reads
  localparam int TA2 = REL + 1;          // slave-driven zero
  localparam int BCW = $clog2(FW + 1);

  smi_state_e    st_q;
  logic [1:0]    op_q;
  logic [AW-1:0] dev_q, reg_q;
  logic          blk_q, bad_q;
  logic [DW-1:0] wd_q, sh_q;
  logic [FW-1:0] sr_q;
  logic [BCW-1:0] cnt_q;
  logic [IW-1:0] fidx_q;
  logic          rd, blk_rd;

  assign rd     = (op_q == OP_RD);
  assign blk_rd = blk_q && rd;
  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      op_q <= '0; dev_q <= '0; reg_q <= '0; blk_q <= 1'b0;
      wd_q <= '0; sh_q <= '0; sr_q <= '0; cnt_q <= '0;
      fidx_q <= '0; bad_q <= 1'b0;
      mdio_o <= 1'b1; dir_o <= 1'b0; mdv_no <= 1'b1;
      done_o <= 1'b0; rd_err_o <= 1'b0;
      cap_we_o <= 1'b0; cap_idx_o <= '0; cap_data_o <= '0;
    end else begin
      done_o   <= 1'b0;
      rd_err_o <= 1'b0;
      cap_we_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          reg_q  <= cmd_i[AW-1:0];
          dev_q  <= cmd_i[2*AW-1:AW];
          op_q   <= cmd_i[2*AW+1:2*AW];
          blk_q  <= cmd_i[2*AW+2];
          wd_q   <= wdata_i;
          fidx_q <= '0;
          bad_q  <= 1'b0;
          st_q   <= ST_ARM;
        end
        ST_ARM: if (rise_i) begin
          mdv_no <= 1'b0;
          sr_q   <= {START_PAT, op_q, dev_q, reg_q,
                     rd ? 2'b11 : TA_WR, rd ? {DW{1'b1}} : wd_q};
          cnt_q  <= '0;
          st_q   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (fall_i) begin
            if (cnt_q == BCW'(FW)) begin
              dir_o  <= 1'b0;
              mdio_o <= 1'b1;
              st_q   <= ST_TAIL;
            end else begin
              mdio_o <= sr_q[FW-1];
              sr_q   <= {sr_q[FW-2:0], 1'b1};
              dir_o  <= !rd || (cnt_q < BCW'(REL));
              cnt_q  <= cnt_q + 1'b1;
            end
          end else if (rise_i && rd) begin
            // cnt_q bits have been driven; the line holds bit cnt_q-1
            if (cnt_q == BCW'(TA2 + 1) && mdio_i) bad_q <= 1'b1;
            if (cnt_q > BCW'(TA2 + 1)) sh_q <= {sh_q[DW-2:0], mdio_i};
            if (cnt_q == BCW'(FW)) begin
              cap_we_o   <= 1'b1;
              cap_idx_o  <= fidx_q;
              cap_data_o <= {sh_q[DW-2:0], mdio_i};
            end
          end
        end
        ST_TAIL: if (rise_i) begin
          mdv_no <= 1'b1;
          if (blk_rd && (fidx_q != IW'(NBLK - 1))) begin
            fidx_q <= fidx_q + 1'b1;
            reg_q  <= reg_q + 1'b1;
            st_q   <= ST_ARM;
          end else begin
            done_o   <= 1'b1;
            rd_err_o <= bad_q;
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smi_master.sv
module smi_master #(
  parameter int DIV  = 10,
  parameter int DW   = 16,
  parameter int AW   = 5,
  parameter int NBLK = 7,
  parameter int RAW  = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic           done_o,
  output logic           rd_err_o,
  output logic           mdc_o,
  output logic           mdio_o,
  input  logic           mdio_i,
  output logic           dir_o,
  output logic           mdv_no
);
  localparam int CMD_W = 2 * AW + 3;
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1;

  logic             rise, fall, busy, start, cap_we;
  logic [CMD_W-1:0] cmd;
  logic [DW-1:0]    wr_data, cap_data;
  logic [IW-1:0]    cap_idx;

  smi_clkgen #(.DIV(DIV)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  smi_regs #(.DW(DW), .AW(AW), .NBLK(NBLK), .RAW(RAW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .start_o   (start),
    .cmd_o     (cmd),
    .wr_o      (wr_data),
    .cap_we_i  (cap_we),
    .cap_idx_i (cap_idx),
    .cap_data_i(cap_data)
  );

  smi_engine #(.DW(DW), .AW(AW), .NBLK(NBLK)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_i     (cmd),
    .wdata_i   (wr_data),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .dir_o     (dir_o),
    .mdv_no    (mdv_no),
    .busy_o    (busy),
    .done_o    (done_o),
    .rd_err_o  (rd_err_o),
    .cap_we_o  (cap_we),
    .cap_idx_o (cap_idx),
    .cap_data_o(cap_data)
  );
endmodule

// File: rtl/smi_master_chk.sv
module smi_master_chk #(
  parameter int DIV = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mdc_o,
  input logic mdio_o,
  input logic dir_o,
  input logic mdv_no,
  input logic done_o,
  input logic rd_err_o
);
  localparam int HALF = DIV / 2;
  localparam int CW = $clog2(DIV) + 1;

  logic          mdc_p;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_p <= 1'b0;
      run_q <= '0;
    end else begin
      mdc_p <= mdc_o;
      run_q <= (mdc_o != mdc_p) ? CW'(1) : run_q + 1'b1;
    end
  end

  // R2
  mdc_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o != mdc_p) |-> (run_q == CW'(HALF)));

  // R4
  mdio_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $fell(mdc_o));

  // R4
  dir_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_o) |-> $fell(mdc_o));

  // R5
  dir_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_o |-> !mdv_no);

  // R6
  strobe_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdv_no) |-> $rose(mdc_o));

  // R6
  strobe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdv_no) |-> $rose(mdc_o));

  // R8
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mdv_no && !dir_o));
endmodule

bind smi_master smi_master_chk #(.DIV(DIV)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mdc_o   (mdc_o),
  .mdio_o  (mdio_o),
  .dir_o   (dir_o),
  .mdv_no  (mdv_no),
  .done_o  (done_o),
  .rd_err_o(rd_err_o)
);

// File: tb/smi_master_test.sv
`timescale 1ns/1ps
module smi_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic done, rd_err, mdc, mdo, dir, mdv_n;
  logic mdi = 1'b1;

  always #2 clk = ~clk;

  smi_master uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .done_o(done), .rd_err_o(rd_err),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_i(mdi), .dir_o(dir), .mdv_no(mdv_n)
  );

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, err_cnt = 0, frames = 0;
  int run = 0, toggles = 0, run_bad = 0, strobe_bad = 0, edge_bad = 0;
  bit finished = 0;

  // slave model state
  logic [15:0] mem [32][32];
  logic cb [32];
  logic cd [32];
  int n = 0;
  bit active = 0;
  bit bad_ta = 0;
  logic mdc_p = 1'b0, mdv_p = 1'b1, mdo_p = 1'b1, dir_p = 1'b0;

  function automatic logic [15:0] pat(int d, int r);
    return {d[4:0], r[4:0], 6'(d * 3 + r)};
  endfunction

  function automatic logic [4:0] fld(int lo);
    logic [4:0] v;
    for (int i = 0; i < 5; i++) v[4-i] = cb[lo+i];
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic rise_e, fall_e;
      rise_e = mdc && !mdc_p;
      fall_e = !mdc && mdc_p;
      if (mdc == mdc_p) run++;
      else begin
        if (toggles > 0 && run != 5) run_bad++;
        toggles++;
        run = 1;
      end
      if (mdv_p && !mdv_n && !rise_e) strobe_bad++;
      if (!mdv_p && mdv_n && !rise_e) strobe_bad++;
      if ((mdo != mdo_p || dir != dir_p) && !fall_e) edge_bad++;
      if (done) done_cnt++;
      if (rd_err) err_cnt++;
      if (mdv_n) begin
        active = 0;
        mdi = 1'b1;
      end else if (rise_e) begin
        if (!active) begin
          active = 1;
          n = 0;
        end else if (n < 32) begin
          cb[n] = mdo;
          cd[n] = dir;
          n++;
          if (n == 32) begin
            frames++;
            if (!(cb[2] == 1'b1 && cb[3] == 1'b0)) begin
              logic [15:0] v;
              for (int i = 0; i < 16; i++) v[15-i] = cb[16+i];
              mem[fld(4)][fld(9)] = v;
            end
          end
        end
      end else if (fall_e && active) begin
        if (cb[2] == 1'b1 && cb[3] == 1'b0 && n >= 14 && n < 32) begin
          if (n == 14) mdi = 1'b1;
          else if (n == 15) mdi = bad_ta;
          else mdi = mem[fld(4)][fld(9)][31-n];
        end else mdi = 1'b1;
      end
    end
    mdc_p = mdc; mdv_p = mdv_n; mdo_p = mdo; dir_p = dir;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_done();
    int c0 = done_cnt;
    while (done_cnt == c0) @(negedge clk);
  endtask

  function automatic logic [15:0] cmdw(bit blk, logic [1:0] op, int d, int r);
    return {3'b0, blk, op, d[4:0], r[4:0]};
  endfunction

  function automatic logic [31:0] frame_bits();
    logic [31:0] f;
    for (int i = 0; i < 32; i++) f[31-i] = cb[i];
    return f;
  endfunction

  function automatic logic [31:0] dir_bits();
    logic [31:0] f;
    for (int i = 0; i < 32; i++) f[31-i] = cd[i];
    return f;
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    check("R1 mdv_no", 32'(mdv_n), 1);
    check("R1 dir_o", 32'(dir), 0);
    check("R1 mdio_o", 32'(mdo), 1);
    rd_reg(4'd0, v); check("R1 ctrl", 32'(v), 0);
    rd_reg(4'd3, v); check("R1 rdata0", 32'(v), 0);
  endtask

  task automatic t_write();
    logic [15:0] v;
    int e0 = err_cnt;
    wr_reg(4'd2, 16'hBEEF);
    wr_reg(4'd1, cmdw(0, 2'b01, 5, 9));
    wr_reg(4'd0, 16'h0001);
    rd_reg(4'd0, v); check("R9 busy after start", 32'(v), 1);
    wait_done();
    rd_reg(4'd0, v); check("R9 start clears", 32'(v), 0);
    check("R3 write frame", frame_bits(), {2'b01, 2'b01, 5'd5, 5'd9, 2'b10, 16'hBEEF});
    check("R5 write dir", dir_bits(), 32'hFFFF_FFFF);
    check("R3 slave got data", 32'(mem[5][9]), 32'h0000_BEEF);
    check("R8 no err on write", 32'(err_cnt - e0), 0);
  endtask

  task automatic t_read(int d, int r, logic [15:0] exp);
    logic [15:0] v;
    int e0 = err_cnt;
    wr_reg(4'd1, cmdw(0, 2'b10, d, r));
    wr_reg(4'd0, 16'h0001);
    wait_done();
    check("R3 read header", frame_bits() >> 18, 32'({2'b01, 2'b10, 5'(d), 5'(r)}));
    check("R5 read dir", dir_bits(), 32'hFFFC_0000);
    rd_reg(4'd3, v); check("R7 read data", 32'(v), 32'(exp));
    check("R8 clean turnaround", 32'(err_cnt - e0), 0);
  endtask

  task automatic t_bad_ta();
    int e0 = err_cnt, d0 = done_cnt;
    bad_ta = 1;
    wr_reg(4'd1, cmdw(0, 2'b10, 3, 4));
    wr_reg(4'd0, 16'h0001);
    wait_done();
    bad_ta = 0;
    check("R8 invalid read flagged", 32'(err_cnt - e0), 1);
    check("R8 single done", 32'(done_cnt - d0), 1);
  endtask

  task automatic t_block();
    logic [15:0] v;
    int f0 = frames, d0 = done_cnt;
    wr_reg(4'd1, cmdw(1, 2'b10, 12, 29));
    wr_reg(4'd0, 16'h0001);
    wait_done();
    check("R10 frame count", 32'(frames - f0), 7);
    check("R10 one done", 32'(done_cnt - d0), 1);
    for (int i = 0; i < 7; i++) begin
      rd_reg(4'(3 + i), v);
      check("R10 block data", 32'(v), 32'(pat(12, (29 + i) % 32)));
    end
  endtask

  task automatic t_busy();
    logic [15:0] v;
    int f0 = frames, d0 = done_cnt;
    wr_reg(4'd2, 16'h1234);
    wr_reg(4'd1, cmdw(0, 2'b10, 1, 1));
    wr_reg(4'd0, 16'h0001);
    repeat (50) @(negedge clk);
    wr_reg(4'd1, cmdw(0, 2'b01, 7, 7));
    wr_reg(4'd2, 16'hFFFF);
    wr_reg(4'd0, 16'h0001);
    rd_reg(4'd1, v); check("R11 cmd kept", 32'(v), 32'(cmdw(0, 2'b10, 1, 1)));
    rd_reg(4'd2, v); check("R11 wdata kept", 32'(v), 32'h1234);
    wait_done();
    repeat (500) @(negedge clk);
    check("R11 no second frame", 32'(frames - f0), 1);
    check("R11 single done", 32'(done_cnt - d0), 1);
    rd_reg(4'd3, v); check("R7 data after busy test", 32'(v), 32'(pat(1, 1)));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int d = 0; d < 32; d++)
      for (int r = 0; r < 32; r++) mem[d][r] = pat(d, r);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_read(5, 9, 16'hBEEF);
    t_read(17, 2, pat(17, 2));
    t_bad_ta();
    t_block();
    t_busy();
    check("R2 mdc runs", 32'(toggles > 100), 1);
    check("R2 half period 5", 32'(run_bad), 0);
    check("R6 strobe on rising mdc", 32'(strobe_bad), 0);
    check("R4 change on falling mdc", 32'(edge_bad), 0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end
endmodule